// File: doc/BRIEF.md
# Interrupt Source Routing Table

This block sits on the source side of an interrupt controller. Each of its `NUM_SRC` level-sensitive, active-low source lines owns one entry in a small table. The entry holds a destination server number, an 8-bit priority and an enable bit. A source that is asserted, enabled, not masked and not already in service becomes a tagged request. The request carries the source's vector and priority and goes to one presentation server, chosen as the entry dictates.

An entry either names one physical server directly or holds the reserved global-queue number. That number equals `2^SRV_BITS - 1 - DIST_IDX`, which is 0xFF by default. A global-queue source is handed to the lowest-numbered server that has joined the queue and is currently accepting. Software programs the table through a four-command register port: read an entry, write server and priority, switch the enable on, switch it off. Each server joins or leaves the queue through a separate membership write. Once a request has gone out, its source stays quiet until the presentation side returns an end-of-interrupt for that vector.

Top module: `src_route_table`

## Requirements
- R1: After reset every entry has server 0, priority 0xFF and enable 0, no server belongs to the global queue, nothing is in service, and `req_valid` is 0.
- R2: Command code 1 (write) stores `cmd_srv` and `cmd_prio` into entry `cmd_idx`. Command code 0 (read) returns that entry's server, priority and enable on `rd_srv`, `rd_prio` and `rd_en` one clock later.
- R3: Command code 2 sets an entry's enable and code 3 clears it. Neither command changes the entry's server or priority.
- R4: A source is forwarded only while its input is low, its enable is 1 and its priority is not 0xFF. A priority of 0xFF blocks the source even when it is enabled.
- R5: A request from source i carries vector `VEC_BASE + i` and the entry's priority. It goes to the named server only while that server's `srv_accept` bit is 1. Otherwise, or if the number names no server and is not the global-queue number, the source waits.
- R6: An entry whose server equals the global-queue number is sent to the lowest-numbered server that is both a member and accepting. It waits while no such server exists.
- R7: A write on the membership port (`gq_wr`) adds server `gq_idx` to the global queue when `gq_join` is 1 and removes it when `gq_join` is 0.
- R8: A forwarded source is not forwarded again until `eoi_valid` arrives with its vector. An end-of-interrupt carrying another vector leaves it untouched.
- R9: A source held back by its enable or its mask is forwarded after it is re-enabled or unmasked, as long as its input is still low. If the input was released in the meantime, nothing is sent.
- R10: At most one request goes out per clock, and the eligible source with the lowest index wins.
- R11: An emitted vector is never 0 and never the inter-processor vector `IPI_VEC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_n | input | NUM_SRC | Level source inputs, active low |
| srv_accept | input | NUM_SRV | Server can take a request this cycle |
| cmd_valid | input | 1 | Register command strobe |
| cmd | input | 2 | 0 read, 1 write, 2 enable, 3 disable |
| cmd_idx | input | log2(NUM_SRC) | Entry addressed |
| cmd_srv | input | SRV_BITS | Server number for write |
| cmd_prio | input | 8 | Priority for write |
| gq_wr | input | 1 | Membership write strobe |
| gq_idx | input | log2(NUM_SRV) | Server whose membership changes |
| gq_join | input | 1 | 1 join, 0 leave |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VEC_W | Vector being retired |
| rd_srv | output | SRV_BITS | Read data: server |
| rd_prio | output | 8 | Read data: priority |
| rd_en | output | 1 | Read data: enable |
| req_valid | output | 1 | Request issued |
| req_vec | output | VEC_W | Request vector |
| req_prio | output | 8 | Request priority |
| req_srv | output | SRV_BITS | Server receiving the request |

## Verification
Every result is due on the first clock edge after the stimulus that causes it. A request is decided from the table, membership and in-service state as they stand before that edge, together with the source and accept levels present at it. Read data also appears after one edge. A table write, an enable change, a membership change or an end-of-interrupt only affects requests one edge later. The bench drives on the falling edge, predicts each request for the coming rising edge from the state before its own updates, and compares on the next falling edge. For that reason a write and the request it unblocks are always checked two cycles apart.

// File: rtl/srt_pkg.sv
package srt_pkg;
    typedef enum logic [1:0] {
        CMD_GET = 2'd0,
        CMD_SET = 2'd1,
        CMD_ON  = 2'd2,
        CMD_OFF = 2'd3
    } cmd_e;
endpackage

// File: rtl/srt_table.sv
module srt_table #(
    parameter int unsigned NUM_SRC  = 8,
    parameter int unsigned SRV_BITS = 8,
    parameter int unsigned PRIO_W   = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cmd_valid,
    input  srt_pkg::cmd_e                      cmd,
    input  logic [$clog2(NUM_SRC)-1:0]         cmd_idx,
    input  logic [SRV_BITS-1:0]                cmd_srv,
    input  logic [PRIO_W-1:0]                  cmd_prio,
    output logic [NUM_SRC-1:0][SRV_BITS-1:0]   tbl_srv,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]     tbl_prio,
    output logic [NUM_SRC-1:0]                 tbl_en,
    output logic [SRV_BITS-1:0]                rd_srv,
    output logic [PRIO_W-1:0]                  rd_prio,
    output logic                               rd_en
);
    typedef struct packed {
        logic [NUM_SRC-1:0][SRV_BITS-1:0] srv;
        logic [NUM_SRC-1:0][PRIO_W-1:0]   prio;
        logic [NUM_SRC-1:0]               en;
        logic [SRV_BITS-1:0]              rd_srv;
        logic [PRIO_W-1:0]                rd_prio;
        logic                             rd_en;
    } tbl_st_t;

    tbl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_valid) begin
            unique case (cmd)
                srt_pkg::CMD_GET: begin
                    st_d.rd_srv  = st_q.srv[cmd_idx];
                    st_d.rd_prio = st_q.prio[cmd_idx];
                    st_d.rd_en   = st_q.en[cmd_idx];
                end
                srt_pkg::CMD_SET: begin
                    st_d.srv[cmd_idx]  = cmd_srv;
                    st_d.prio[cmd_idx] = cmd_prio;
                end
                srt_pkg::CMD_ON:  st_d.en[cmd_idx] = 1'b1;
                srt_pkg::CMD_OFF: st_d.en[cmd_idx] = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.srv     <= '0;
            st_q.prio    <= '1;
            st_q.en      <= '0;
            st_q.rd_srv  <= '0;
            st_q.rd_prio <= '1;
            st_q.rd_en   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl_srv  = st_q.srv;
    assign tbl_prio = st_q.prio;
    assign tbl_en   = st_q.en;
    assign rd_srv   = st_q.rd_srv;
    assign rd_prio  = st_q.rd_prio;
    assign rd_en    = st_q.rd_en;
endmodule

// File: rtl/srt_gq.sv
module srt_gq #(
    parameter int unsigned NUM_SRV = 4,
    localparam int unsigned SIDX_W = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gq_wr,
    input  logic [SIDX_W-1:0]  gq_idx,
    input  logic               gq_join,
    input  logic [NUM_SRV-1:0] srv_accept,
    output logic               gq_ok,
    output logic [SIDX_W-1:0]  gq_pick
);
    typedef struct packed {
        logic [NUM_SRV-1:0] member;
    } gq_st_t;

    gq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (gq_wr) st_d.member[gq_idx] = gq_join;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // lowest-numbered member that can take a request
    always_comb begin
        gq_ok   = 1'b0;
        gq_pick = '0;
        for (int j = NUM_SRV - 1; j >= 0; j--) begin
            if (st_q.member[j] && srv_accept[j]) begin
                gq_ok   = 1'b1;
                gq_pick = SIDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/srt_select.sv
module srt_select #(
    parameter int unsigned NUM_SRC  = 8,
    parameter int unsigned NUM_SRV  = 4,
    parameter int unsigned SRV_BITS = 8,
    parameter int unsigned PRIO_W   = 8,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 16,
    parameter logic [SRV_BITS-1:0] GQ_ID = '1,
    localparam int unsigned SIDX_W  = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1,
    localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               src_n,
    input  logic [NUM_SRC-1:0][SRV_BITS-1:0] tbl_srv,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]   tbl_prio,
    input  logic [NUM_SRC-1:0]               tbl_en,
    input  logic [NUM_SRV-1:0]               srv_accept,
    input  logic                             gq_ok,
    input  logic [SIDX_W-1:0]                gq_pick,
    input  logic                             eoi_valid,
    input  logic [VEC_W-1:0]                 eoi_vec,
    output logic                             req_valid,
    output logic [VEC_W-1:0]                 req_vec,
    output logic [PRIO_W-1:0]                req_prio,
    output logic [SRV_BITS-1:0]              req_srv
);
    typedef struct packed {
        logic [NUM_SRC-1:0] inflight;
        logic               valid;
        logic [VEC_W-1:0]   vec;
        logic [PRIO_W-1:0]  prio;
        logic [SRV_BITS-1:0] srv;
    } sel_st_t;

    sel_st_t st_d, st_q;
    logic [VEC_W-1:0] eoi_off;
    logic             hit;
    logic             elig;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        hit        = 1'b0;
        elig       = 1'b0;
        eoi_off    = eoi_vec - VEC_W'(VEC_BASE);
        // retire the in-service flag named by an end-of-interrupt
        if (eoi_valid && eoi_vec >= VEC_W'(VEC_BASE) && eoi_off < VEC_W'(NUM_SRC))
            st_d.inflight[eoi_off[IDX_W-1:0]] = 1'b0;
        // fixed order: lowest index wins
        for (int i = 0; i < NUM_SRC; i++) begin
            elig = !src_n[i] && tbl_en[i] && (tbl_prio[i] != '1) && !st_q.inflight[i];
            if (!hit && elig) begin
                if (tbl_srv[i] == GQ_ID) begin
                    if (gq_ok) begin
                        hit    = 1'b1;
                        st_d.srv = SRV_BITS'(gq_pick);
                    end
                end else if (tbl_srv[i] < SRV_BITS'(NUM_SRV)) begin
                    if (srv_accept[tbl_srv[i][SIDX_W-1:0]]) begin
                        hit    = 1'b1;
                        st_d.srv = tbl_srv[i];
                    end
                end
                if (hit) begin
                    st_d.valid       = 1'b1;
                    st_d.vec         = VEC_W'(VEC_BASE) + VEC_W'(i);
                    st_d.prio        = tbl_prio[i];
                    st_d.inflight[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_valid = st_q.valid;
    assign req_vec   = st_q.vec;
    assign req_prio  = st_q.prio;
    assign req_srv   = st_q.srv;
endmodule

// File: rtl/src_route_table.sv
module src_route_table #(
    parameter int unsigned NUM_SRC  = 8,
    parameter int unsigned NUM_SRV  = 4,
    parameter int unsigned SRV_BITS = 8,
    parameter int unsigned DIST_IDX = 0,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_BASE = 16,
    parameter int unsigned IPI_VEC  = 2,
    localparam int unsigned PRIO_W  = 8,
    localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int unsigned SIDX_W  = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_n,
    input  logic [NUM_SRV-1:0]  srv_accept,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd,
    input  logic [IDX_W-1:0]    cmd_idx,
    input  logic [SRV_BITS-1:0] cmd_srv,
    input  logic [PRIO_W-1:0]   cmd_prio,
    input  logic                gq_wr,
    input  logic [SIDX_W-1:0]   gq_idx,
    input  logic                gq_join,
    input  logic                eoi_valid,
    input  logic [VEC_W-1:0]    eoi_vec,
    output logic [SRV_BITS-1:0] rd_srv,
    output logic [PRIO_W-1:0]   rd_prio,
    output logic                rd_en,
    output logic                req_valid,
    output logic [VEC_W-1:0]    req_vec,
    output logic [PRIO_W-1:0]   req_prio,
    output logic [SRV_BITS-1:0] req_srv
);
    localparam logic [SRV_BITS-1:0] GQ_ID =
        SRV_BITS'((64'd1 << SRV_BITS) - 64'd1 - 64'(DIST_IDX));

    logic [NUM_SRC-1:0][SRV_BITS-1:0] tbl_srv;
    logic [NUM_SRC-1:0][PRIO_W-1:0]   tbl_prio;
    logic [NUM_SRC-1:0]               tbl_en;
    logic                             gq_ok;
    logic [SIDX_W-1:0]                gq_pick;

    srt_table #(.NUM_SRC(NUM_SRC), .SRV_BITS(SRV_BITS), .PRIO_W(PRIO_W)) u_table (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(srt_pkg::cmd_e'(cmd)),
        .cmd_idx(cmd_idx), .cmd_srv(cmd_srv), .cmd_prio(cmd_prio),
        .tbl_srv(tbl_srv), .tbl_prio(tbl_prio), .tbl_en(tbl_en),
        .rd_srv(rd_srv), .rd_prio(rd_prio), .rd_en(rd_en)
    );

    srt_gq #(.NUM_SRV(NUM_SRV)) u_gq (
        .clk(clk), .rst_n(rst_n), .gq_wr(gq_wr), .gq_idx(gq_idx), .gq_join(gq_join),
        .srv_accept(srv_accept), .gq_ok(gq_ok), .gq_pick(gq_pick)
    );

    srt_select #(
        .NUM_SRC(NUM_SRC), .NUM_SRV(NUM_SRV), .SRV_BITS(SRV_BITS), .PRIO_W(PRIO_W),
        .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .GQ_ID(GQ_ID)
    ) u_select (
        .clk(clk), .rst_n(rst_n), .src_n(src_n), .tbl_srv(tbl_srv), .tbl_prio(tbl_prio),
        .tbl_en(tbl_en), .srv_accept(srv_accept), .gq_ok(gq_ok), .gq_pick(gq_pick),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .req_valid(req_valid),
        .req_vec(req_vec), .req_prio(req_prio), .req_srv(req_srv)
    );
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
    parameter int unsigned NUM_SRV  = 4,
    parameter int unsigned SRV_BITS = 8,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned IPI_VEC  = 2,
    localparam int unsigned SIDX_W  = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRV-1:0]  srv_accept,
    input logic                req_valid,
    input logic [VEC_W-1:0]    req_vec,
    input logic [7:0]          req_prio,
    input logic [SRV_BITS-1:0] req_srv
);
    logic [NUM_SRV-1:0] acc_q;
    always_ff @(posedge clk) acc_q <= srv_accept;

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_vec != '0 && req_vec != VEC_W'(IPI_VEC))); // R11
    AST_PRIO_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_prio != 8'hFF)); // R4
    AST_TARGET_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_srv < SRV_BITS'(NUM_SRV) && acc_q[req_srv[SIDX_W-1:0]])); // R5
    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !(req_valid && req_vec == $past(req_vec))); // R8
endmodule

bind src_route_table srt_checker #(
    .NUM_SRV(NUM_SRV), .SRV_BITS(SRV_BITS), .VEC_W(VEC_W), .IPI_VEC(IPI_VEC)
) u_srt_checker (
    .clk(clk), .rst_n(rst_n), .srv_accept(srv_accept), .req_valid(req_valid),
    .req_vec(req_vec), .req_prio(req_prio), .req_srv(req_srv)
);

// File: tb/test_src_route_table.sv
`timescale 1ns/1ps
module test_src_route_table;
    localparam int NS = 8, NV = 4, VB = 16;

    logic       clk = 0, rst_n = 0;
    logic [7:0] src_n = 8'hFF;
    logic [3:0] srv_accept = 4'h0;
    logic       cmd_valid = 0;
    logic [1:0] cmd = 0;
    logic [2:0] cmd_idx = 0;
    logic [7:0] cmd_srv = 0, cmd_prio = 0;
    logic       gq_wr = 0, gq_join = 0;
    logic [1:0] gq_idx = 0;
    logic       eoi_valid = 0;
    logic [7:0] eoi_vec = 0;
    logic [7:0] rd_srv, rd_prio, req_vec, req_prio, req_srv;
    logic       rd_en, req_valid;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [7:0] m_srv [NS];
    logic [7:0] m_prio [NS];
    bit m_en [NS], m_inf [NS], m_mem [NV];
    bit e_valid, e_rd;
    int e_vec, e_prio, e_srv, e_rsrv, e_rprio, e_ren;

    always #4 clk = ~clk;

    src_route_table i_src_route_table (
        .clk(clk), .rst_n(rst_n), .src_n(src_n), .srv_accept(srv_accept),
        .cmd_valid(cmd_valid), .cmd(cmd), .cmd_idx(cmd_idx), .cmd_srv(cmd_srv),
        .cmd_prio(cmd_prio), .gq_wr(gq_wr), .gq_idx(gq_idx), .gq_join(gq_join),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .rd_srv(rd_srv), .rd_prio(rd_prio),
        .rd_en(rd_en), .req_valid(req_valid), .req_vec(req_vec), .req_prio(req_prio),
        .req_srv(req_srv)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // requirement model: predict the coming edge, then apply its state changes
    task automatic predict();
        bit found = 0;
        e_valid = 0; e_rd = 0;
        for (int i = 0; i < NS; i++) begin
            if (!found && !src_n[i] && m_en[i] && m_prio[i] != 8'hFF && !m_inf[i]) begin
                int t = -1;
                if (m_srv[i] == 8'hFF) begin
                    for (int j = NV - 1; j >= 0; j--) if (m_mem[j] && srv_accept[j]) t = j;
                end else if (m_srv[i] < NV && srv_accept[m_srv[i][1:0]]) t = int'(m_srv[i]);
                if (t >= 0) begin
                    found = 1; e_valid = 1; e_vec = VB + i; e_prio = m_prio[i]; e_srv = t;
                end
            end
        end
        if (cmd_valid && cmd == 2'd0) begin
            e_rd = 1; e_rsrv = m_srv[cmd_idx]; e_rprio = m_prio[cmd_idx]; e_ren = m_en[cmd_idx];
        end
        if (eoi_valid && eoi_vec >= VB && eoi_vec < VB + NS) m_inf[eoi_vec - VB] = 0;
        if (e_valid) m_inf[e_vec - VB] = 1;
        if (cmd_valid) begin
            case (cmd)
                2'd1: begin m_srv[cmd_idx] = cmd_srv; m_prio[cmd_idx] = cmd_prio; end
                2'd2: m_en[cmd_idx] = 1;
                2'd3: m_en[cmd_idx] = 0;
                default: ;
            endcase
        end
        if (gq_wr) m_mem[gq_idx] = gq_join;
    endtask

    task automatic cyc(input string tag);
        predict();
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0; gq_wr = 0; eoi_valid = 0;
        chk(req_valid === e_valid, {tag, " req_valid"}, int'(req_valid), int'(e_valid));
        if (e_valid && req_valid) begin
            chk(req_vec == e_vec, {tag, " req_vec"}, req_vec, e_vec);
            chk(req_srv == e_srv, {tag, " req_srv"}, req_srv, e_srv);
            chk(req_prio == e_prio, {tag, " req_prio"}, req_prio, e_prio);
        end
        if (req_valid)
            chk(req_vec != 0 && req_vec != 2, "R11 reserved vector", req_vec, VB);
        if (e_rd) begin
            chk(rd_srv == e_rsrv, "R2 rd_srv", rd_srv, e_rsrv);
            chk(rd_prio == e_rprio, "R2 rd_prio", rd_prio, e_rprio);
            chk(rd_en == e_ren, "R3 rd_en", int'(rd_en), e_ren);
        end
    endtask

    task automatic do_cmd(input int c, input int idx, input int s, input int p, input string tag);
        cmd_valid = 1; cmd = 2'(c); cmd_idx = 3'(idx); cmd_srv = 8'(s); cmd_prio = 8'(p);
        cyc(tag);
    endtask

    task automatic do_gq(input int idx, input bit j, input string tag);
        gq_wr = 1; gq_idx = 2'(idx); gq_join = j;
        cyc(tag);
    endtask

    task automatic do_eoi(input int v, input string tag);
        eoi_valid = 1; eoi_vec = 8'(v);
        cyc(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NS; i++) begin m_srv[i] = 0; m_prio[i] = 8'hFF; m_en[i] = 0; m_inf[i] = 0; end
        for (int j = 0; j < NV; j++) m_mem[j] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        src_n = 8'h00; srv_accept = 4'hF;
        cyc("R1 masked at reset");
        chk(req_valid == 0, "R1 no request after reset", int'(req_valid), 0);
        do_cmd(0, 3, 0, 0, "R1 read");
        chk(rd_srv == 0 && rd_prio == 8'hFF && rd_en == 0, "R1 reset entry", rd_prio, 255);
        // R2 write then read back
        do_cmd(1, 3, 1, 5, "R2 write");
        do_cmd(0, 3, 0, 0, "R2 read");
        chk(rd_srv == 1 && rd_prio == 5, "R2 readback prio", rd_prio, 5);
        // R3 enable keeps fields; request follows
        do_cmd(2, 3, 7, 9, "R3 enable");
        do_cmd(0, 3, 0, 0, "R5 first request");
        chk(rd_srv == 1 && rd_prio == 5 && rd_en == 1, "R3 enable keeps fields", rd_prio, 5);
        chk(req_valid && req_vec == 19 && req_srv == 1, "R5 direct route", req_vec, 19);
        cyc("R8 held after forward");
        do_eoi(20, "R8 foreign eoi");
        do_eoi(19, "R8 own eoi");
        cyc("R8 reissue");
        chk(req_valid && req_vec == 19, "R8 reissued after eoi", req_vec, 19);
        // R5 pending on busy server
        srv_accept = 4'b1011;
        do_cmd(1, 4, 2, 7, "R5 write");
        do_cmd(2, 4, 0, 0, "R5 enable");
        cyc("R5 waits busy");
        srv_accept = 4'hF;
        cyc("R5 served when ready");
        do_cmd(1, 6, 9, 3, "R5 write bad server");
        do_cmd(2, 6, 0, 0, "R5 enable bad server");
        cyc("R5 bad server waits");
        // R4 mask independent of enable
        do_cmd(1, 5, 0, 255, "R4 masked write");
        do_cmd(2, 5, 0, 0, "R4 enable masked");
        cyc("R4 masked stays quiet");
        chk(req_valid == 0, "R4 mask blocks", int'(req_valid), 0);
        do_cmd(1, 5, 0, 3, "R9 unmask");
        cyc("R9 after unmask");
        // R9 disabled source released before enable
        do_cmd(1, 7, 0, 1, "R9 write");
        src_n[7] = 1;
        cyc("R9 input released");
        do_cmd(2, 7, 0, 0, "R9 enable released");
        cyc("R9 nothing sent");
        chk(!(req_valid && req_vec == 23), "R9 released source silent", req_vec, 0);
        src_n[7] = 0;
        cyc("R9 reasserted");
        // R6 / R7 global queue
        do_cmd(1, 0, 255, 2, "R6 write global");
        do_cmd(2, 0, 0, 0, "R6 enable global");
        cyc("R6 no members");
        srv_accept = 4'b1010;
        do_gq(3, 1, "R7 join 3");
        do_gq(1, 1, "R7 join 1");
        cyc("R6 lowest member");
        do_eoi(16, "R6 eoi");
        srv_accept = 4'b1000;
        cyc("R6 next member");
        do_gq(3, 0, "R7 leave 3");
        do_eoi(16, "R7 eoi");
        cyc("R7 nonmember ignored");
        // R10 ordering
        srv_accept = 4'hF;
        do_cmd(1, 1, 0, 9, "R10 write");
        do_cmd(1, 2, 0, 9, "R10 write");
        do_cmd(2, 2, 0, 0, "R10 enable");
        do_cmd(2, 1, 0, 0, "R10 enable");
        cyc("R10 first");
        cyc("R10 second");
        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            src_n = 8'($urandom & $urandom);
            srv_accept = 4'($urandom);
            if ($urandom % 3 == 0) begin
                eoi_valid = 1;
                eoi_vec = ($urandom % 5 == 0) ? 8'($urandom) : 8'(VB + $urandom % NS);
            end
            if ($urandom % 4 == 0) begin
                int s = $urandom % 6;
                cmd_valid = 1; cmd = 2'($urandom); cmd_idx = 3'($urandom);
                cmd_srv = (s < 4) ? 8'(s) : (s == 4 ? 8'hFF : 8'd9);
                cmd_prio = ($urandom % 5 == 0) ? 8'hFF : 8'($urandom % 8);
            end
            if ($urandom % 8 == 0) begin gq_wr = 1; gq_idx = 2'($urandom); gq_join = 1'($urandom); end
            cyc("R10 random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule